// File: doc/BRIEF.md
# One-Time-Programmable Fuse Controller

This block sits on a simple 32-bit register bus and manages a small array of one-time-programmable fuse words. Each fuse word has a shadow register that software reads through a window of the address map. A fuse word can only be programmed after an unlock key has been placed in the control register. The controller reads the addressed fuse word and removes from the program data every bit that is already blown. It then strobes the remaining data into the fuse one bit at a time, shifting the data register right with zero fill. After programming, a reload copies every fuse word into its shadow register.

Each word has a write lock and a read lock, loaded through dedicated preload ports. Any access that breaks a lock sets a sticky error flag and does not touch the fuse array. While that flag is set, the controller refuses new program, reload and shadow accesses until software clears it. Program and reload timing are taken from a timing register, counted in clock cycles.

Top module: `fusectl`

## Requirements
- R1: After reset, CTRL (0x000) reads 0, DATA (0x020) reads 0 and TIMING (0x010) reads 0x0001_1002.
- R2: CTRL holds the target word in bits [7:0], BUSY in bit 8, ERROR in bit 9, RELOAD in bit 10 and the unlock field in bits [31:16]. A write to 0x004 ORs the data into the target and unlock fields and writes to 0x008 AND-NOT them. Reads at 0x004 and 0x008 return CTRL.
- R3: A write to DATA starts programming only when the unlock field holds 0x3E77. Any write to DATA while BUSY is clear resets the unlock field to 0. Without the key, a DATA write only stores the value and BUSY stays clear.
- R4: When programming is accepted, BUSY is set and DATA holds the written value with every bit already blown in the target word cleared. Once programming completes, the fuse word equals its old value ORed with the written value.
- R5: Programming takes exactly 32*(P+R+1) cycles, where P is TIMING[11:0] and R is TIMING[15:12]. DATA shifts right with zero fill once per bit, so it reads 0 when programming is done.
- R6: The target word is latched when programming is accepted. Writes to CTRL during programming do not change which fuse word is programmed.
- R7: Bus writes to DATA while BUSY is set are ignored.
- R8: A program request to a write-locked word, or to a word index beyond the array, sets ERROR. It leaves BUSY clear and the fuse word unchanged.
- R9: ERROR stays set until a write to 0x008 with bit 9 set. While ERROR is set, armed DATA writes and reload requests are ignored, and shadow reads return 0xBADABADA.
- R10: A read of a read-locked shadow word returns 0xBADABADA and sets ERROR.
- R11: A shadow write to a write-locked word, or any shadow write while a reload runs, sets ERROR and leaves the shadow unchanged. Otherwise a shadow write updates the shadow.
- R12: Writing bit 10 to 0x004 while idle starts a reload. During the reload, RELOAD and BUSY read 1. The reload copies every fuse word into its shadow in ascending order, each copy taking TIMING[21:16]+1 cycles, and then clears both bits.
- R13: Shadow word i is at byte address 0x400 + 0x10*i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Byte address of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; data appears on bus_rdata after the next edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| lk_we | input | 1 | Lock preload strobe (test use only) |
| lk_idx | input | 4 | Word index for lock preload |
| lk_wr | input | 1 | Write-lock value to preload |
| lk_rd | input | 1 | Read-lock value to preload |

## Verification
The assertions assume that the bus never raises read and write strobes in the same cycle. They also assume that lock preload never happens while a program or reload is running, so a lock that was checked at acceptance still holds when a fuse bit is blown. The bench issues one bus operation per cycle and preloads locks only when BUSY reads clear. It waits for BUSY to drop before each reload or new program. The only exception is the stimulus that deliberately targets a busy controller.

// File: rtl/fusectl_pkg.sv
package fusectl_pkg;
  localparam int DW = 32;
  localparam logic [11:0] A_CTRL = 12'h000;
  localparam logic [11:0] A_SET  = 12'h004;
  localparam logic [11:0] A_CLR  = 12'h008;
  localparam logic [11:0] A_TIM  = 12'h010;
  localparam logic [11:0] A_DATA = 12'h020;
  localparam logic [15:0] UNLOCK_KEY  = 16'h3E77;
  localparam logic [31:0] LOCKED_WORD = 32'hBADA_BADA;
  typedef enum logic [1:0] {ENG_IDLE, ENG_PROG, ENG_LOAD} eng_state_e;
endpackage

// File: rtl/fusectl_engine.sv
module fusectl_engine
  import fusectl_pkg::*;
#(
  parameter int WORDS = 16,
  parameter int IW    = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          prog_go,
  input  logic [IW-1:0] prog_addr,
  input  logic [DW-1:0] prog_data,
  input  logic          load_go,
  input  logic          data_we,
  input  logic [DW-1:0] data_wdata,
  input  logic [11:0]   t_prog,
  input  logic [3:0]    t_relax,
  input  logic [5:0]    t_read,
  output logic          busy,
  output logic          loading,
  output logic [DW-1:0] data_q,
  output logic          blow_en,
  output logic [IW-1:0] blow_addr,
  output logic [4:0]    blow_bit,
  output logic          copy_en,
  output logic [IW-1:0] copy_idx
);
  localparam logic [IW-1:0] LAST_IDX = IW'(WORDS - 1);

  eng_state_e    state;
  logic [12:0]   cnt;
  logic [4:0]    bitpos;
  logic [IW-1:0] idx;
  logic [IW-1:0] lat_addr;
  logic [12:0]   step_len;

  assign step_len = {1'b0, t_prog} + 13'(t_relax);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ENG_IDLE;
      cnt      <= '0;
      bitpos   <= '0;
      idx      <= '0;
      lat_addr <= '0;
      data_q   <= '0;
    end else begin
      case (state)
        ENG_IDLE: begin
          if (prog_go) begin
            state    <= ENG_PROG;
            lat_addr <= prog_addr;
            data_q   <= prog_data;
            cnt      <= step_len;
            bitpos   <= '0;
          end else if (load_go) begin
            state <= ENG_LOAD;
            idx   <= '0;
            cnt   <= 13'(t_read);
          end else if (data_we) begin
            data_q <= data_wdata;
          end
        end
        ENG_PROG: begin
          if (cnt == '0) begin
            data_q <= {1'b0, data_q[DW-1:1]};
            bitpos <= bitpos + 5'd1;
            cnt    <= step_len;
            if (bitpos == 5'd31) state <= ENG_IDLE;
          end else begin
            cnt <= cnt - 13'd1;
          end
        end
        ENG_LOAD: begin
          if (cnt == '0) begin
            idx <= idx + 1'b1;
            cnt <= 13'(t_read);
            if (idx == LAST_IDX) state <= ENG_IDLE;
          end else begin
            cnt <= cnt - 13'd1;
          end
        end
        default: state <= ENG_IDLE;
      endcase
    end
  end

  assign busy      = (state != ENG_IDLE);
  assign loading   = (state == ENG_LOAD);
  assign blow_en   = (state == ENG_PROG) && (cnt == '0) && data_q[0];
  assign blow_addr = lat_addr;
  assign blow_bit  = bitpos;
  assign copy_en   = (state == ENG_LOAD) && (cnt == '0);
  assign copy_idx  = idx;

  // R6: the latched target word holds for the whole program operation
  assert_latched_addr_R6: assert property (@(posedge clk) disable iff (rst)
    (state == ENG_PROG && $past(state) == ENG_PROG) |-> $stable(lat_addr));

  // R5: every shift brings a zero into the top bit
  assert_zero_fill_R5: assert property (@(posedge clk) disable iff (rst)
    (state == ENG_PROG && cnt == '0) |=> (data_q[DW-1] == 1'b0));

  // R7: bus data never reaches the shift register while busy
  assert_data_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (state == ENG_PROG && cnt != '0) |=> $stable(data_q));
endmodule

// File: rtl/fusectl_array.sv
module fusectl_array
  import fusectl_pkg::*;
#(
  parameter int WORDS = 16,
  parameter int IW    = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             blow_en,
  input  logic [IW-1:0]    blow_addr,
  input  logic [4:0]       blow_bit,
  input  logic             copy_en,
  input  logic [IW-1:0]    copy_idx,
  input  logic             sh_we,
  input  logic [IW-1:0]    sh_idx,
  input  logic [DW-1:0]    sh_wdata,
  input  logic             lk_we,
  input  logic [IW-1:0]    lk_idx,
  input  logic             lk_wr,
  input  logic             lk_rd,
  input  logic [IW-1:0]    fuse_ridx,
  output logic [DW-1:0]    fuse_rword,
  output logic [DW-1:0]    sh_rword,
  output logic [WORDS-1:0] wlock,
  output logic [WORDS-1:0] rlock
);
  logic [DW-1:0] fuse_q [WORDS];
  logic [DW-1:0] shadow [WORDS];
  logic          sp_we;
  logic [IW-1:0] sp_idx;
  logic [DW-1:0] sp_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < WORDS; i++) fuse_q[i] <= '0;
      wlock <= '0;
      rlock <= '0;
    end else begin
      if (blow_en) fuse_q[blow_addr][blow_bit] <= 1'b1;
      if (lk_we) begin
        wlock[lk_idx] <= lk_wr;
        rlock[lk_idx] <= lk_rd;
      end
    end
  end

  // single write port keeps the shadow store mappable to RAM
  assign sp_we   = copy_en | sh_we;
  assign sp_idx  = copy_en ? copy_idx : sh_idx;
  assign sp_data = copy_en ? fuse_q[copy_idx] : sh_wdata;

  always_ff @(posedge clk) begin
    if (sp_we) shadow[sp_idx] <= sp_data;
  end

  assign fuse_rword = fuse_q[fuse_ridx];
  assign sh_rword   = shadow[sh_idx];

  // R11: a bus shadow write never competes with a reload copy
  assert_one_shadow_port_R11: assert property (@(posedge clk) disable iff (rst)
    !(copy_en && sh_we));

  // R8: no fuse bit is ever blown in a write-locked word
  assert_blow_unlocked_R8: assert property (@(posedge clk) disable iff (rst)
    blow_en |-> !wlock[blow_addr]);
endmodule

// File: rtl/fusectl.sv
module fusectl
  import fusectl_pkg::*;
#(
  parameter int          WORDS      = 16,
  parameter logic [31:0] TIMING_RST = 32'h0001_1002
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [11:0]              bus_addr,
  input  logic                     bus_wr,
  input  logic                     bus_rd,
  input  logic [31:0]              bus_wdata,
  output logic [31:0]              bus_rdata,
  input  logic                     lk_we,
  input  logic [$clog2(WORDS)-1:0] lk_idx,
  input  logic                     lk_wr,
  input  logic                     lk_rd
);
  localparam int IW = $clog2(WORDS);

  logic [7:0]       ctrl_addr;
  logic [15:0]      ctrl_key;
  logic             ctrl_err;
  logic [21:0]      tim_q;
  logic             busy, loading;
  logic [DW-1:0]    data_q;
  logic             blow_en, copy_en;
  logic [IW-1:0]    blow_addr, copy_idx;
  logic [4:0]       blow_bit;
  logic [DW-1:0]    fuse_rword, sh_rword;
  logic [WORDS-1:0] wlock, rlock;

  logic wr_ctrl, wr_set, wr_clr, wr_tim, wr_data, sh_hit, wr_sh, rd_sh;
  logic armed, addr_ok, prog_req, prog_go, prog_bad, data_we, load_go;
  logic sh_we, sh_bad_wr, sh_bad_rd;
  logic [IW-1:0] tgt, sh_idx;
  logic [31:0]   ctrl_rd;

  assign wr_ctrl = bus_wr && bus_addr == A_CTRL;
  assign wr_set  = bus_wr && bus_addr == A_SET;
  assign wr_clr  = bus_wr && bus_addr == A_CLR;
  assign wr_tim  = bus_wr && bus_addr == A_TIM;
  assign wr_data = bus_wr && bus_addr == A_DATA;
  assign sh_hit  = bus_addr[11:10] == 2'b01 && bus_addr[3:0] == 4'h0
                   && 32'(bus_addr[9:4]) < WORDS;
  assign sh_idx  = bus_addr[4 +: IW];
  assign wr_sh   = bus_wr && sh_hit;
  assign rd_sh   = bus_rd && sh_hit;

  assign armed    = ctrl_key == UNLOCK_KEY;
  assign addr_ok  = 32'(ctrl_addr) < WORDS;
  assign tgt      = ctrl_addr[IW-1:0];
  assign prog_req = wr_data && !busy && armed && !ctrl_err;
  assign prog_go  = prog_req && addr_ok && !wlock[tgt];
  assign prog_bad = prog_req && !(addr_ok && !wlock[tgt]);
  assign data_we  = wr_data && !busy && !armed;
  assign load_go  = wr_set && bus_wdata[10] && !busy && !ctrl_err;
  assign sh_we     = wr_sh && !loading && !wlock[sh_idx] && !ctrl_err;
  assign sh_bad_wr = wr_sh && (loading || wlock[sh_idx]);
  assign sh_bad_rd = rd_sh && rlock[sh_idx] && !ctrl_err;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_addr <= '0;
      ctrl_key  <= '0;
      ctrl_err  <= 1'b0;
      tim_q     <= TIMING_RST[21:0];
    end else begin
      if (wr_ctrl) begin
        ctrl_addr <= bus_wdata[7:0];
        ctrl_key  <= bus_wdata[31:16];
      end
      if (wr_set) begin
        ctrl_addr <= ctrl_addr | bus_wdata[7:0];
        ctrl_key  <= ctrl_key | bus_wdata[31:16];
      end
      if (wr_clr) begin
        ctrl_addr <= ctrl_addr & ~bus_wdata[7:0];
        ctrl_key  <= ctrl_key & ~bus_wdata[31:16];
        if (bus_wdata[9]) ctrl_err <= 1'b0;
      end
      if (wr_tim) tim_q <= bus_wdata[21:0];
      if (wr_data && !busy) ctrl_key <= '0;
      if (prog_bad || sh_bad_wr || sh_bad_rd) ctrl_err <= 1'b1;
    end
  end

  assign ctrl_rd = {ctrl_key, 5'b0, loading, ctrl_err, busy, ctrl_addr};

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      case (bus_addr)
        A_CTRL, A_SET, A_CLR: bus_rdata <= ctrl_rd;
        A_TIM:                bus_rdata <= {10'b0, tim_q};
        A_DATA:               bus_rdata <= data_q;
        default: begin
          if (sh_hit) bus_rdata <= (ctrl_err || rlock[sh_idx]) ? LOCKED_WORD : sh_rword;
          else        bus_rdata <= '0;
        end
      endcase
    end
  end

  fusectl_engine #(.WORDS(WORDS), .IW(IW)) u_engine (
    .clk(clk), .rst(rst),
    .prog_go(prog_go), .prog_addr(tgt), .prog_data(bus_wdata & ~fuse_rword),
    .load_go(load_go), .data_we(data_we), .data_wdata(bus_wdata),
    .t_prog(tim_q[11:0]), .t_relax(tim_q[15:12]), .t_read(tim_q[21:16]),
    .busy(busy), .loading(loading), .data_q(data_q),
    .blow_en(blow_en), .blow_addr(blow_addr), .blow_bit(blow_bit),
    .copy_en(copy_en), .copy_idx(copy_idx)
  );

  fusectl_array #(.WORDS(WORDS), .IW(IW)) u_array (
    .clk(clk), .rst(rst),
    .blow_en(blow_en), .blow_addr(blow_addr), .blow_bit(blow_bit),
    .copy_en(copy_en), .copy_idx(copy_idx),
    .sh_we(sh_we), .sh_idx(sh_idx), .sh_wdata(bus_wdata),
    .lk_we(lk_we), .lk_idx(lk_idx), .lk_wr(lk_wr), .lk_rd(lk_rd),
    .fuse_ridx(tgt), .fuse_rword(fuse_rword), .sh_rword(sh_rword),
    .wlock(wlock), .rlock(rlock)
  );

  // R3: any DATA write while idle consumes the key
  assert_key_consumed_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == A_DATA && !busy) |=> (ctrl_key == '0));

  // R8: a locked program request leaves the engine idle and flags ERROR
  assert_lock_no_busy_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_data && !busy && armed && !ctrl_err && addr_ok && wlock[tgt]) |=> (!busy && ctrl_err));

  // R9: ERROR only drops through the clear alias
  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (ctrl_err && !(bus_wr && bus_addr == A_CLR && bus_wdata[9])) |=> ctrl_err);

  // R12: a reload never starts while ERROR is set
  assert_no_reload_on_err_R12: assert property (@(posedge clk) disable iff (rst)
    (ctrl_err && !busy) |=> !loading);
endmodule

// File: tb/fusectl_tb.sv
module fusectl_tb;
  localparam logic [11:0] A_CTRL = 12'h000, A_SET = 12'h004, A_CLR = 12'h008;
  localparam logic [11:0] A_TIM  = 12'h010, A_DATA = 12'h020;
  localparam logic [31:0] KEYW   = 32'h3E77_0000;
  localparam logic [31:0] MARK   = 32'hBADA_BADA;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        lk_we = 1'b0, lk_wr = 1'b0, lk_rd = 1'b0;
  logic [3:0]  lk_idx = '0;

  int nvec = 0, nbad = 0;
  bit done = 1'b0;
  logic [31:0] exp_fuse [16];

  always #5 clk = ~clk;

  fusectl u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .lk_we(lk_we), .lk_idx(lk_idx), .lk_wr(lk_wr), .lk_rd(lk_rd)
  );

  function automatic logic [11:0] sh(input int i);
    return 12'h400 + 12'(16 * i);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bw(input logic [11:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic br(input logic [11:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 4000; i++) begin
      br(A_CTRL, v);
      if (!v[8]) break;
    end
  endtask

  task automatic reload();
    bw(A_SET, 32'h0000_0400);
    wait_idle();
  endtask

  task automatic set_lock(input int i, input logic w, input logic r);
    lk_idx = 4'(i); lk_wr = w; lk_rd = r; lk_we = 1'b1;
    @(negedge clk);
    lk_we = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    br(A_CTRL, v); chk("R1 ctrl", v, 32'h0);
    br(A_DATA, v); chk("R1 data", v, 32'h0);
    br(A_TIM, v);  chk("R1 timing", v, 32'h0001_1002);
  endtask

  task automatic t_alias();
    logic [31:0] v;
    bw(A_CTRL, 32'h05);
    bw(A_SET, 32'h30);
    br(A_SET, v); chk("R2 set alias", v, 32'h35);
    bw(A_CLR, 32'h01);
    br(A_CLR, v); chk("R2 clr alias", v, 32'h34);
    br(A_CTRL, v); chk("R2 ctrl", v, 32'h34);
    bw(A_CTRL, 32'h0);
  endtask

  task automatic t_nokey();
    logic [31:0] v;
    bw(A_DATA, 32'hA5);
    br(A_CTRL, v); chk("R3 no key stays idle", v, 32'h0);
    br(A_DATA, v); chk("R3 data stored", v, 32'hA5);
  endtask

  task automatic t_program();
    logic [31:0] v;
    bw(A_CTRL, KEYW | 32'h3);
    bw(A_DATA, 32'h0000_F00F);
    br(A_DATA, v); chk("R4 masked data", v, 32'h0000_F00F);
    br(A_CTRL, v); chk("R3 key cleared busy set", v, 32'h0000_0103);
    wait_idle();
    exp_fuse[3] = 32'h0000_F00F;
    bw(A_TIM, 32'h0001_2003);
    bw(A_CTRL, KEYW | 32'h4);
    bw(A_DATA, 32'h8000_0001);
    begin
      int n = 0;
      for (int i = 0; i < 4000; i++) begin
        br(A_CTRL, v);
        if (!v[8]) break;
        n++;
      end
      chk("R5 program length", 32'(n), 32'd192);
    end
    exp_fuse[4] = 32'h8000_0001;
    br(A_DATA, v); chk("R5 zero fill", v, 32'h0);
    reload();
    br(sh(3), v); chk("R4 word3", v, exp_fuse[3]);
    br(sh(4), v); chk("R13 word4", v, exp_fuse[4]);
    bw(A_CTRL, KEYW | 32'h3);
    bw(A_DATA, 32'h0000_00FF);
    br(A_DATA, v); chk("R4 already-blown bits masked", v, 32'h0000_00F0);
    wait_idle();
    exp_fuse[3] = 32'h0000_F0FF;
    reload();
    br(sh(3), v); chk("R4 or result", v, exp_fuse[3]);
  endtask

  task automatic t_latch();
    logic [31:0] v;
    bw(A_CTRL, KEYW | 32'h5);
    bw(A_DATA, 32'h0000_0003);
    bw(A_CTRL, 32'h6);
    bw(A_DATA, 32'hFFFF_FFFF);
    wait_idle();
    exp_fuse[5] = 32'h3;
    br(A_DATA, v); chk("R7 busy write ignored", v, 32'h0);
    reload();
    br(sh(5), v); chk("R6 latched word", v, exp_fuse[5]);
    br(sh(6), v); chk("R6 other word untouched", v, exp_fuse[6]);
  endtask

  task automatic t_wlock();
    logic [31:0] v;
    set_lock(7, 1'b1, 1'b0);
    bw(A_CTRL, KEYW | 32'h7);
    bw(A_DATA, 32'h1);
    br(A_CTRL, v); chk("R8 locked program", v, 32'h0000_0207);
    bw(A_SET, 32'h400);
    br(A_CTRL, v); chk("R9 reload refused on error", v & 32'h0000_0700, 32'h0000_0200);
    br(sh(0), v); chk("R9 read refused on error", v, MARK);
    bw(A_CTRL, KEYW | 32'h1);
    bw(A_DATA, 32'h80);
    br(A_CTRL, v); chk("R9 program refused on error", v, 32'h0000_0201);
    bw(A_CLR, 32'h200);
    br(A_CTRL, v); chk("R9 error cleared", v & 32'h200, 32'h0);
    reload();
    br(sh(7), v); chk("R8 word unchanged", v, exp_fuse[7]);
    br(sh(1), v); chk("R9 word1 unchanged", v, exp_fuse[1]);
  endtask

  task automatic t_rlock();
    logic [31:0] v;
    set_lock(9, 1'b0, 1'b1);
    br(sh(9), v); chk("R10 marker", v, MARK);
    br(A_CTRL, v); chk("R10 error set", v & 32'h200, 32'h200);
    bw(A_CLR, 32'h200);
  endtask

  task automatic t_shadow_wr();
    logic [31:0] v;
    bw(sh(2), 32'h0000_1234);
    br(sh(2), v); chk("R11 shadow write", v, 32'h0000_1234);
    bw(sh(7), 32'h0000_5555);
    br(A_CTRL, v); chk("R11 locked shadow write", v & 32'h200, 32'h200);
    bw(A_CLR, 32'h200);
    br(sh(7), v); chk("R11 locked shadow kept", v, exp_fuse[7]);
    bw(A_SET, 32'h400);
    br(A_CTRL, v); chk("R12 reload visible", v & 32'h500, 32'h500);
    bw(sh(0), 32'h0000_DEAD);
    wait_idle();
    br(A_CTRL, v); chk("R11 write during reload", v & 32'h700, 32'h200);
    bw(A_CLR, 32'h200);
    br(sh(0), v); chk("R11 shadow kept during reload", v, exp_fuse[0]);
    br(sh(2), v); chk("R12 reload restores", v, exp_fuse[2]);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) exp_fuse[i] = 32'h0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_alias();
    t_nokey();
    t_program();
    t_latch();
    t_wlock();
    t_rlock();
    t_shadow_wr();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nvec++;
      nbad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end
endmodule